// File: doc/BRIEF.md
# Half-Symbol-Spaced Transmit Pre-Emphasis Combiner

This block is the digital core of a ten-tap transmit pre-emphasis filter whose taps are spaced half a symbol apart. It runs on a clock at twice the symbol rate, so one clock cycle is one half-symbol slot. A new NRZ bit enters on every symbol-boundary slot and is held there for two slots. A delay line then passes it down one stage per slot. Because each stage holds a bit for a whole symbol while its neighbour lags by half a symbol, adjacent taps overlap by one slot. The effective weight seen at any slot is therefore the sum of two tap settings, which lets the filter shape the transition (edge) samples as well as the data samples.

In every slot the block forms a signed sum. Each filled stage adds its tap magnitude with a sign taken from its bit and its per-tap invert control. The sum is limited to a programmable peak swing and sent out as one two's-complement code for the driver DAC. The first four taps take wide magnitudes and the other six take narrow ones. A new configuration is staged on a load strobe and is switched in only at a symbol boundary. A flag reports when the active magnitudes add up to more than the swing limit.

Top module: `xfir_tx`

## Requirements
- R1: While reset is asserted, and on release before any weights are loaded, `code_o` is 0 and `over_limit_o` is 0.
- R2: The first rising edge after reset release is a symbol boundary, and boundaries then fall on every second edge. On a boundary edge, stage 0 takes `sym_bit_i`, which is ignored on the other edges. Stage k holds that bit for two slots, starting k slots after stage 0.
- R3: A stage contributes +weight when (bit XOR invert) is 1 and −weight when it is 0. Bit 1 means +1, bit 0 means −1, and invert 1 flips the sign.
- R4: In the slot after each edge, `code_o` equals the sum of all stage contributions formed from the state before that edge. Adjacent taps overlap, so a single bit is shaped by the sum of two neighbouring tap settings.
- R5: `cfg_wt_i` packs unsigned magnitudes with tap 0 in the lowest bits. Taps 0..3 are 7 bits each, at bit offset 7·k. Taps 4..9 are 5 bits each, at offset 28+5·(k−4).
- R6: Weights and inverts are captured only on an edge where `cfg_load_i` is 1, and are ignored otherwise. A captured set becomes active on the next boundary edge strictly after the capture, so both slots of a symbol always use the same set.
- R7: `code_o` is clamped to ±SWING (default 400). `over_limit_o` is 1 exactly when the magnitudes of the active set add up to more than SWING. The flag updates when a set becomes active.
- R8: Stages not yet filled since reset contribute 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-symbol slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_bit_i | input | 1 | NRZ data bit, taken on boundary edges |
| cfg_load_i | input | 1 | Strobe capturing weights and inverts |
| cfg_wt_i | input | 58 | Packed tap magnitudes |
| cfg_inv_i | input | 10 | Per-tap sign inversion |
| code_o | output | 11 | Signed output code per slot |
| over_limit_o | output | 1 | Active magnitude sum exceeds swing |

## Verification
The hardest situation to reach from the ports is a configuration change racing the symbol boundary. This covers a load that lands on the boundary edge itself while an earlier staged set is still waiting, and a load that lands on the mid-symbol edge. To reach it, the stimulus changes the weight bus on every slot and raises the load strobe at random in both phases, so loads fall on boundaries, off boundaries and back to back. Single-tap sweeps, taken over every tap and both invert settings, then separate the timing of each stage and the sign rule.

// File: rtl/xfir_pkg.sv
package xfir_pkg;

    localparam int unsigned DEF_NTAP      = 10;
    localparam int unsigned DEF_WIDE_TAPS = 4;
    localparam int unsigned DEF_WIDE_W    = 7;
    localparam int unsigned DEF_NARROW_W  = 5;
    localparam int unsigned DEF_SWING     = 400;

    typedef enum logic {
        PH_BOUND = 1'b0,
        PH_MID   = 1'b1
    } slot_ph_e;

    // Bit offset of tap k inside the packed weight bus.
    function automatic int unsigned tap_off(int unsigned k, int unsigned nwide,
                                            int unsigned ww, int unsigned nw);
        if (k < nwide) return k * ww;
        return nwide * ww + (k - nwide) * nw;
    endfunction

endpackage

// File: rtl/xfir_line.sv
module xfir_line
    import xfir_pkg::*;
#(
    parameter int unsigned NTAP = DEF_NTAP
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            din_i,
    output logic            bnd_o,
    output logic [NTAP-1:0] bit_o,
    output logic [NTAP-1:0] vld_o
);

    typedef struct packed {
        slot_ph_e        ph;
        logic [NTAP-1:0] bits;
        logic [NTAP-1:0] vld;
    } line_st_t;

    line_st_t line_d, line_q;

    always_comb begin
        line_d = line_q;
        line_d.ph = (line_q.ph == PH_BOUND) ? PH_MID : PH_BOUND;
        for (int k = NTAP - 1; k > 0; k--) begin
            line_d.bits[k] = line_q.bits[k-1];
            line_d.vld[k]  = line_q.vld[k-1];
        end
        if (line_q.ph == PH_BOUND) begin
            line_d.bits[0] = din_i;
            line_d.vld[0]  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '{ph: PH_BOUND, bits: '0, vld: '0};
        else        line_q <= line_d;
    end

    assign bnd_o = (line_q.ph == PH_BOUND);
    assign bit_o = line_q.bits;
    assign vld_o = line_q.vld;

    // R2: boundary and mid slots alternate
    assert_phase_alt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_q.ph == PH_BOUND) |=> (line_q.ph == PH_MID));
    assert_phase_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_q.ph == PH_MID) |=> (line_q.ph == PH_BOUND));
    // R2: stage 0 holds its bit across the mid-symbol edge
    assert_stage0_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_q.ph == PH_MID) |=> $stable(line_q.bits[0]));

endmodule

// File: rtl/xfir_cfg.sv
module xfir_cfg
    import xfir_pkg::*;
#(
    parameter int unsigned NTAP      = DEF_NTAP,
    parameter int unsigned WIDE_TAPS = DEF_WIDE_TAPS,
    parameter int unsigned WIDE_W    = DEF_WIDE_W,
    parameter int unsigned NARROW_W  = DEF_NARROW_W,
    parameter int unsigned SWING     = DEF_SWING,
    parameter int unsigned WT_BITS   = 58,
    parameter int unsigned SUM_W     = 11
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_i,
    input  logic [WT_BITS-1:0]          wt_i,
    input  logic [NTAP-1:0]             inv_i,
    input  logic                        bnd_i,
    output logic [NTAP-1:0][WIDE_W-1:0] wt_o,
    output logic [NTAP-1:0]             inv_o,
    output logic                        over_o
);

    typedef struct packed {
        logic [NTAP-1:0][WIDE_W-1:0] shw;
        logic [NTAP-1:0]             shinv;
        logic                        pend;
        logic [NTAP-1:0][WIDE_W-1:0] actw;
        logic [NTAP-1:0]             actinv;
        logic                        over;
    } cfg_st_t;

    cfg_st_t cfg_d, cfg_q;
    logic [NTAP-1:0][WIDE_W-1:0] unp;
    logic [SUM_W-1:0]            mag_sum;

    for (genvar k = 0; k < NTAP; k++) begin : g_unpack
        localparam int unsigned OFF = tap_off(k, WIDE_TAPS, WIDE_W, NARROW_W);
        if (k < WIDE_TAPS) begin : g_wide
            assign unp[k] = wt_i[OFF +: WIDE_W];
        end else begin : g_narrow
            assign unp[k] = {{(WIDE_W-NARROW_W){1'b0}}, wt_i[OFF +: NARROW_W]};
        end
    end

    always_comb begin
        mag_sum = '0;
        for (int k = 0; k < NTAP; k++) mag_sum = mag_sum + SUM_W'(cfg_q.shw[k]);
    end

    always_comb begin
        cfg_d = cfg_q;
        if (bnd_i && cfg_q.pend) begin
            cfg_d.actw   = cfg_q.shw;
            cfg_d.actinv = cfg_q.shinv;
            cfg_d.pend   = 1'b0;
            cfg_d.over   = (mag_sum > SUM_W'(SWING));
        end
        if (load_i) begin
            cfg_d.shw   = unp;
            cfg_d.shinv = inv_i;
            cfg_d.pend  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign wt_o   = cfg_q.actw;
    assign inv_o  = cfg_q.actinv;
    assign over_o = cfg_q.over;

    // R6: the active set never changes on a mid-symbol edge
    assert_act_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd_i |=> ($stable(cfg_q.actw) && $stable(cfg_q.actinv) && $stable(cfg_q.over)));

endmodule

// File: rtl/xfir_sum.sv
module xfir_sum
    import xfir_pkg::*;
#(
    parameter int unsigned NTAP   = DEF_NTAP,
    parameter int unsigned WIDE_W = DEF_WIDE_W,
    parameter int unsigned SUM_W  = 11,
    parameter int unsigned SWING  = DEF_SWING
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NTAP-1:0]             bit_i,
    input  logic [NTAP-1:0]             vld_i,
    input  logic [NTAP-1:0][WIDE_W-1:0] wt_i,
    input  logic [NTAP-1:0]             inv_i,
    output logic signed [SUM_W-1:0]     code_o
);

    localparam logic signed [SUM_W-1:0] LIM  = SUM_W'(SWING);
    localparam logic signed [SUM_W-1:0] NLIM = -LIM;

    typedef struct packed {
        logic signed [SUM_W-1:0] code;
    } sum_st_t;

    sum_st_t sum_d, sum_q;
    logic signed [SUM_W-1:0] acc;
    logic        [SUM_W-1:0] mag;

    always_comb begin
        acc = '0;
        mag = '0;
        for (int k = 0; k < NTAP; k++) begin
            mag = SUM_W'(wt_i[k]);
            if (vld_i[k]) begin
                if (bit_i[k] ^ inv_i[k]) acc = acc + $signed(mag);
                else                     acc = acc - $signed(mag);
            end
        end
    end

    always_comb begin
        sum_d = sum_q;
        if (acc > LIM)       sum_d.code = LIM;
        else if (acc < NLIM) sum_d.code = NLIM;
        else                 sum_d.code = acc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end

    assign code_o = sum_q.code;

    // R7: output never leaves the swing window
    assert_code_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_q.code <= LIM) && (sum_q.code >= NLIM));
    // R8: an empty delay line yields a zero code
    assert_empty_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i == '0) |=> (sum_q.code == '0));

endmodule

// File: rtl/xfir_tx.sv
module xfir_tx
    import xfir_pkg::*;
#(
    parameter int unsigned NTAP      = DEF_NTAP,
    parameter int unsigned WIDE_TAPS = DEF_WIDE_TAPS,
    parameter int unsigned WIDE_W    = DEF_WIDE_W,
    parameter int unsigned NARROW_W  = DEF_NARROW_W,
    parameter int unsigned SWING     = DEF_SWING,
    localparam int unsigned WT_BITS  = tap_off(NTAP, WIDE_TAPS, WIDE_W, NARROW_W),
    localparam int unsigned MAXSUM   = WIDE_TAPS * ((1 << WIDE_W) - 1)
                                     + (NTAP - WIDE_TAPS) * ((1 << NARROW_W) - 1),
    localparam int unsigned SUM_W    = $clog2(MAXSUM + 1) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sym_bit_i,
    input  logic                    cfg_load_i,
    input  logic [WT_BITS-1:0]      cfg_wt_i,
    input  logic [NTAP-1:0]         cfg_inv_i,
    output logic signed [SUM_W-1:0] code_o,
    output logic                    over_limit_o
);

    logic                        bnd;
    logic [NTAP-1:0]             stage_bit;
    logic [NTAP-1:0]             stage_vld;
    logic [NTAP-1:0][WIDE_W-1:0] act_wt;
    logic [NTAP-1:0]             act_inv;

    xfir_line #(.NTAP(NTAP)) i_line (
        .clk   (clk),
        .rst_n (rst_n),
        .din_i (sym_bit_i),
        .bnd_o (bnd),
        .bit_o (stage_bit),
        .vld_o (stage_vld)
    );

    xfir_cfg #(
        .NTAP(NTAP), .WIDE_TAPS(WIDE_TAPS), .WIDE_W(WIDE_W), .NARROW_W(NARROW_W),
        .SWING(SWING), .WT_BITS(WT_BITS), .SUM_W(SUM_W)
    ) i_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cfg_load_i),
        .wt_i   (cfg_wt_i),
        .inv_i  (cfg_inv_i),
        .bnd_i  (bnd),
        .wt_o   (act_wt),
        .inv_o  (act_inv),
        .over_o (over_limit_o)
    );

    xfir_sum #(.NTAP(NTAP), .WIDE_W(WIDE_W), .SUM_W(SUM_W), .SWING(SWING)) i_sum (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_i  (stage_bit),
        .vld_i  (stage_vld),
        .wt_i   (act_wt),
        .inv_i  (act_inv),
        .code_o (code_o)
    );

endmodule

// File: tb/test_xfir_tx.sv
module test_xfir_tx;

    localparam int NT = 10;
    localparam int SW = 400;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               sym_bit_i = 1'b0;
    logic               cfg_load_i = 1'b0;
    logic [57:0]        cfg_wt_i = '0;
    logic [NT-1:0]      cfg_inv_i = '0;
    logic signed [10:0] code_o;
    logic               over_limit_o;

    xfir_tx i_xfir_tx (
        .clk(clk), .rst_n(rst_n), .sym_bit_i(sym_bit_i), .cfg_load_i(cfg_load_i),
        .cfg_wt_i(cfg_wt_i), .cfg_inv_i(cfg_inv_i), .code_o(code_o),
        .over_limit_o(over_limit_o)
    );

    always #5 clk = ~clk;

    int n_tot = 0;
    int n_fail = 0;

    int cur_w [NT];
    int m_bit [NT];
    int m_vld [NT];
    int sh_w  [NT];
    int ac_w  [NT];
    logic [NT-1:0] sh_inv, ac_inv;
    int m_ph, m_pend, m_over;

    task automatic chk(input string tag, input int act, input int exp);
        n_tot++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // R5 packing: taps 0..3 at 7*k (7 bits), taps 4..9 at 28+5*(k-4) (5 bits)
    task automatic pack_w();
        logic [57:0] v = '0;
        for (int k = 0; k < NT; k++) begin
            if (k < 4) v[k*7 +: 7] = 7'(cur_w[k]);
            else       v[28+(k-4)*5 +: 5] = 5'(cur_w[k]);
        end
        cfg_wt_i = v;
    endtask

    function automatic int wmax(input int k);
        return (k < 4) ? 127 : 31;
    endfunction

    function automatic int m_code();
        int s = 0;
        for (int k = 0; k < NT; k++)
            if (m_vld[k] != 0) s += ((m_bit[k] != 0) ^ ac_inv[k]) ? ac_w[k] : -ac_w[k];
        if (s > SW)  s = SW;
        if (s < -SW) s = -SW;
        return s;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < NT; k++) begin
            m_bit[k] = 0; m_vld[k] = 0; sh_w[k] = 0; ac_w[k] = 0;
        end
        sh_inv = '0; ac_inv = '0; m_ph = 0; m_pend = 0; m_over = 0;
    endtask

    task automatic step(input string tag);
        int exp_code;
        int s;
        @(posedge clk);
        exp_code = m_code();
        for (int k = NT - 1; k > 0; k--) begin
            m_bit[k] = m_bit[k-1]; m_vld[k] = m_vld[k-1];
        end
        if (m_ph == 0) begin
            m_bit[0] = int'(sym_bit_i); m_vld[0] = 1;
            if (m_pend != 0) begin
                s = 0;
                for (int k = 0; k < NT; k++) begin ac_w[k] = sh_w[k]; s += sh_w[k]; end
                ac_inv = sh_inv; m_pend = 0; m_over = (s > SW) ? 1 : 0;
            end
        end
        if (cfg_load_i) begin
            for (int k = 0; k < NT; k++) sh_w[k] = cur_w[k];
            sh_inv = cfg_inv_i; m_pend = 1;
        end
        m_ph ^= 1;
        @(negedge clk);
        chk(tag, int'(code_o), exp_code);
        chk("R7 flag", int'(over_limit_o), m_over);
    endtask

    task automatic load_now(input string tag);
        pack_w();
        cfg_load_i = 1'b1;
        step(tag);
        cfg_load_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tot++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        model_reset();
        for (int k = 0; k < NT; k++) cur_w[k] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset code", int'(code_o), 0);
        chk("R1 reset flag", int'(over_limit_o), 0);
        rst_n = 1'b1;
        step("R1 after release");

        // R8: fill the line with unit weights, empty stages add nothing
        for (int k = 0; k < NT; k++) cur_w[k] = 1;
        cfg_inv_i = '0;
        load_now("R8 load");
        for (int i = 0; i < 24; i++) begin
            sym_bit_i = 1'($urandom_range(0, 1));
            step("R8 fill");
        end

        // R2 R3 R5: single-tap sweep over every tap and both invert values
        for (int k = 0; k < NT; k++) begin
            for (int iv = 0; iv < 2; iv++) begin
                for (int j = 0; j < NT; j++) cur_w[j] = 0;
                cur_w[k] = wmax(k);
                cfg_inv_i = '0;
                cfg_inv_i[k] = 1'(iv);
                load_now("R5 tap load");
                for (int i = 0; i < 30; i++) begin
                    sym_bit_i = 1'($urandom_range(0, 1));
                    step((k < 4) ? "R2/R3/R5 wide tap" : "R2/R3/R5 narrow tap");
                end
            end
        end

        // R4: overlapping shaping, isolated ones in a zero stream
        cur_w = '{8, 24, 40, 24, 8, 4, 2, 1, 1, 1};
        cfg_inv_i = 10'b0000010001;
        load_now("R4 load");
        for (int i = 0; i < 60; i++) begin
            if (i % 2 == 0) sym_bit_i = (i % 16 == 4) ? 1'b1 : 1'b0;
            step("R4 overlap sum");
        end

        // R6: weight bus changes every slot, loads land on either phase
        for (int i = 0; i < 400; i++) begin
            for (int k = 0; k < NT; k++) cur_w[k] = $urandom_range(0, (k < 4) ? 60 : 20);
            pack_w();
            cfg_inv_i = 10'($urandom);
            cfg_load_i = ($urandom_range(0, 4) == 0);
            sym_bit_i = 1'($urandom_range(0, 1));
            step("R6 staged load");
        end
        cfg_load_i = 1'b0;

        // R7: full-scale weights exceed the swing and clamp
        for (int k = 0; k < NT; k++) cur_w[k] = wmax(k);
        cfg_inv_i = '0;
        load_now("R7 load");
        for (int i = 0; i < 40; i++) begin
            sym_bit_i = (i < 24) ? 1'b1 : 1'b0;
            step("R7 clamp");
        end

        // R7: back under the limit clears the flag
        for (int k = 0; k < NT; k++) cur_w[k] = 10;
        load_now("R7 reload");
        for (int i = 0; i < 6; i++) step("R7 flag clear");

        finish_run();
    end

endmodule